// File: doc/BRIEF.md
# Control Transfer Stage Sequencer

This block runs the data and status stages of a control transfer on the default endpoint. The setup stage has already been decoded when it starts. A one-cycle `setup_valid` strobe brings in three values: the direction, the length the host asked for, and, for device-to-host requests, how many bytes the device has ready to return. From then on the block reacts to two event pulses from the packet engine: an IN packet was acknowledged, or an OUT packet arrived together with its byte count. In return it issues commands:

- transmit a data packet, with a length and a buffer offset;
- transmit an empty status packet;
- open the endpoint to OUT data;
- stall.

The block tracks the remaining length and the buffer offset itself. It also decides when a reply must end with an empty packet. When a transfer closes cleanly it pulses one of two completion strobes, one per direction. Request parsing, descriptor content and packet storage are handled elsewhere. The block only orders the packets and checks their lengths.

Top module: `ctrl_xfer_seq`

## Requirements
- R1: After reset the block is idle. `cmd_send`, `cmd_zlp`, `cmd_stall`, `done_tx`, `done_rx` and `out_open` are all 0.
- R2: A device-to-host reply is `min(reply, requested, MAX_XFER)` bytes long. It goes out as `cmd_send` pulses. Each pulse carries `cmd_len = min(MPS, bytes left)`, and `cmd_offset` starts at 0 and grows by MPS per packet. A reply of 0 bytes is one send of length 0.
- R3: `cmd_send` and `cmd_zlp` are raised only in a cycle where `in_busy`, `in_done`, `out_rcvd` and `setup_valid` are all 0. While any of them is high, the command waits.
- R4: A trailing send of length 0 (offset 0) follows the last data packet only in one case. The clamped reply must be nonzero, shorter than the clamped request, and a whole multiple of MPS.
- R5: After the IN completion of the final data packet, `out_open` goes to 1. The next OUT packet, of any length, pulses `done_tx` and returns the block to idle, so `out_open` drops to 0.
- R6: A host-to-device setup sets `out_open` to 1. Each OUT packet must hold `min(MPS, clamped request − bytes received so far)` bytes. Any other length pulses `cmd_stall` and returns the block to idle.
- R7: After the last OUT data packet, `cmd_zlp` is pulsed once `in_busy` is low. The following `in_done` pulses `done_rx` and returns the block to idle.
- R8: Some events pulse `cmd_stall` and return the block to idle. These are an `in_done` when no IN packet is outstanding, and an `out_rcvd` while OUT is not open. `in_done` takes precedence when both events arrive in the same cycle.
- R9: `setup_valid` aborts any transfer in progress and reloads all counters. In its own cycle it suppresses `cmd_send` and `cmd_stall`.
- R10: A host-to-device request longer than MAX_XFER is clamped to MAX_XFER, so exactly MAX_XFER/MPS full packets are expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Decoded setup stage strobe; starts or restarts a transfer |
| setup_dir_in | input | 1 | 1 = device-to-host data stage |
| setup_req_len | input | LEN_W | Length requested by the host |
| setup_reply_len | input | LEN_W | Bytes the device has ready to return |
| in_busy | input | 1 | Engine still holds an earlier IN packet |
| in_done | input | 1 | An IN packet was acknowledged by the host |
| out_rcvd | input | 1 | An OUT packet was received |
| out_len | input | PKT_W | Byte count of the received OUT packet |
| cmd_send | output | 1 | Transmit a data packet |
| cmd_len | output | PKT_W | Length for `cmd_send` |
| cmd_offset | output | LEN_W | Buffer offset for `cmd_send` |
| cmd_zlp | output | 1 | Transmit an empty IN status packet |
| out_open | output | 1 | Accept OUT tokens instead of answering NAK |
| cmd_stall | output | 1 | Stall the endpoint |
| done_tx | output | 1 | Device-to-host transfer completed |
| done_rx | output | 1 | Host-to-device transfer completed |

## Verification
Replies are tried at four kinds of length, and each kind separates a different fault:

- **Zero bytes:** shows whether the empty first packet is handled.
- **An exact multiple of MPS below the request:** shows whether the trailing empty packet appears.
- **An exact multiple equal to the request:** shows whether it is wrongly added.
- **Lengths with a partial tail:** check the tail size and the offset steps.

Requests above MAX_XFER are applied in both directions to separate the clamp from plain length tracking. Random `in_busy` hold-offs are mixed in to catch any command issued early. Directed out-of-order events, a wrong OUT length and a mid-transfer setup show whether the stall and abort paths reach idle or leave stale state behind.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIN,
    ST_DIN_LAST,
    ST_STAT_OUT,
    ST_DOUT,
    ST_DOUT_LAST,
    ST_STAT_IN
  } seq_state_e;

  function automatic int unsigned umin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // trailing empty packet: reply nonzero, shorter than asked, whole packets
  function automatic logic zlp_rule(input int unsigned reply, input int unsigned req,
                                    input int unsigned mps);
    return (reply != 0) && (reply < req) && ((reply % mps) == 0);
  endfunction

  function automatic logic is_out_state(input seq_state_e s);
    return (s == ST_DOUT) || (s == ST_DOUT_LAST) || (s == ST_STAT_OUT);
  endfunction

endpackage

// File: rtl/ctrl_seq_in_track.sv
module ctrl_seq_in_track #(
  parameter int LEN_W = 16,
  parameter int MPS   = 64,
  parameter int PKT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_zlp,
  input  logic             advance,
  output logic [PKT_W-1:0] chunk_len,
  output logic [LEN_W-1:0] offset,
  output logic             last_chunk,
  output logic             zlp_owed
);
  import ctrl_seq_pkg::*;

  localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MPS);

  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] off_q;
  logic             zlp_q;

  assign chunk_len  = PKT_W'(umin(32'(rem_q), MPS));
  assign last_chunk = (rem_q <= MPS_L);
  assign offset     = off_q;
  assign zlp_owed   = zlp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      off_q <= '0;
      zlp_q <= 1'b0;
    end else if (load) begin
      rem_q <= load_len;
      off_q <= '0;
      zlp_q <= load_zlp;
    end else if (advance) begin
      if (last_chunk) begin
        rem_q <= '0;
        off_q <= '0;
        zlp_q <= 1'b0;
      end else begin
        rem_q <= rem_q - MPS_L;
        off_q <= off_q + MPS_L;
      end
    end
  end

endmodule

// File: rtl/ctrl_seq_out_track.sv
module ctrl_seq_out_track #(
  parameter int LEN_W = 16,
  parameter int MPS   = 64,
  parameter int PKT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             accept,
  output logic [PKT_W-1:0] expect_len,
  output logic             tail_next
);
  import ctrl_seq_pkg::*;

  localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MPS);

  logic [LEN_W-1:0] req_q;
  logic [LEN_W-1:0] got_q;
  logic [LEN_W-1:0] left_w;
  logic [LEN_W-1:0] after_w;

  assign left_w     = req_q - got_q;
  assign expect_len = PKT_W'(umin(32'(left_w), MPS));
  assign after_w    = left_w - LEN_W'(expect_len);
  assign tail_next  = (after_w <= MPS_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      got_q <= '0;
    end else if (load) begin
      req_q <= load_len;
      got_q <= '0;
    end else if (accept) begin
      got_q <= got_q + LEN_W'(expect_len);
    end
  end

endmodule

// File: rtl/ctrl_xfer_seq.sv
module ctrl_xfer_seq #(
  parameter int LEN_W    = 16,
  parameter int MPS      = 64,
  parameter int MAX_XFER = 1024,
  localparam int PKT_W   = $clog2(MPS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic             setup_dir_in,
  input  logic [LEN_W-1:0] setup_req_len,
  input  logic [LEN_W-1:0] setup_reply_len,
  input  logic             in_busy,
  input  logic             in_done,
  input  logic             out_rcvd,
  input  logic [PKT_W-1:0] out_len,
  output logic             cmd_send,
  output logic [PKT_W-1:0] cmd_len,
  output logic [LEN_W-1:0] cmd_offset,
  output logic             cmd_zlp,
  output logic             out_open,
  output logic             cmd_stall,
  output logic             done_tx,
  output logic             done_rx
);
  import ctrl_seq_pkg::*;

  localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MPS);

  seq_state_e state_q, state_d;
  logic       tx_owed_q, tx_owed_d;

  // clamped setup values
  logic [LEN_W-1:0] req_c;
  logic [LEN_W-1:0] reply_c;
  logic             zlp_ld;

  assign req_c   = LEN_W'(umin(32'(setup_req_len), MAX_XFER));
  assign reply_c = LEN_W'(umin(32'(setup_reply_len), 32'(req_c)));
  assign zlp_ld  = zlp_rule(32'(reply_c), 32'(req_c), MPS);

  // tracker outputs
  logic [PKT_W-1:0] chunk_len;
  logic [LEN_W-1:0] chunk_off;
  logic             last_chunk;
  logic             zlp_owed;
  logic [PKT_W-1:0] expect_len;
  logic             tail_next;

  // named internal events
  logic ev_in, ev_out, in_legal, out_legal, len_bad;
  logic ev_in_ok, ev_out_ok, tx_ok;

  assign ev_in     = in_done && !setup_valid;
  assign ev_out    = out_rcvd && !in_done && !setup_valid;
  assign in_legal  = ((state_q == ST_DIN) && !tx_owed_q) || (state_q == ST_DIN_LAST) ||
                     ((state_q == ST_STAT_IN) && !tx_owed_q);
  assign out_legal = is_out_state(state_q);
  assign len_bad   = ((state_q == ST_DOUT) || (state_q == ST_DOUT_LAST)) &&
                     (out_len != expect_len);
  assign ev_in_ok  = ev_in && in_legal;
  assign ev_out_ok = ev_out && out_legal && !len_bad;
  assign tx_ok     = !setup_valid && !in_done && !out_rcvd && !in_busy && tx_owed_q;

  assign cmd_send   = tx_ok && (state_q == ST_DIN);
  assign cmd_zlp    = tx_ok && (state_q == ST_STAT_IN);
  assign cmd_len    = chunk_len;
  assign cmd_offset = chunk_off;
  assign cmd_stall  = (ev_in && !in_legal) || (ev_out && (!out_legal || len_bad));
  assign out_open   = out_legal;
  assign done_tx    = ev_out_ok && (state_q == ST_STAT_OUT);
  assign done_rx    = ev_in_ok && (state_q == ST_STAT_IN);

  ctrl_seq_in_track #(.LEN_W(LEN_W), .MPS(MPS), .PKT_W(PKT_W)) in_trk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (setup_valid),
    .load_len   (reply_c),
    .load_zlp   (zlp_ld),
    .advance    (cmd_send),
    .chunk_len  (chunk_len),
    .offset     (chunk_off),
    .last_chunk (last_chunk),
    .zlp_owed   (zlp_owed)
  );

  ctrl_seq_out_track #(.LEN_W(LEN_W), .MPS(MPS), .PKT_W(PKT_W)) out_trk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (setup_valid),
    .load_len   (req_c),
    .accept     (ev_out_ok),
    .expect_len (expect_len),
    .tail_next  (tail_next)
  );

  always_comb begin
    state_d   = state_q;
    tx_owed_d = tx_owed_q;
    if (setup_valid) begin
      tx_owed_d = setup_dir_in;
      if (setup_dir_in)        state_d = ST_DIN;
      else if (req_c > MPS_L)  state_d = ST_DOUT;
      else                     state_d = ST_DOUT_LAST;
    end else if (cmd_stall) begin
      state_d   = ST_IDLE;
      tx_owed_d = 1'b0;
    end else if (cmd_send) begin
      tx_owed_d = 1'b0;
      if (last_chunk && !zlp_owed) state_d = ST_DIN_LAST;
    end else if (cmd_zlp) begin
      tx_owed_d = 1'b0;
    end else if (ev_in_ok) begin
      unique case (state_q)
        ST_DIN:      tx_owed_d = 1'b1;
        ST_DIN_LAST: state_d   = ST_STAT_OUT;
        default:     state_d   = ST_IDLE;
      endcase
    end else if (ev_out_ok) begin
      unique case (state_q)
        ST_DOUT: if (tail_next) state_d = ST_DOUT_LAST;
        ST_DOUT_LAST: begin
          state_d   = ST_STAT_IN;
          tx_owed_d = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tx_owed_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      tx_owed_q <= tx_owed_d;
    end
  end

endmodule

// File: rtl/ctrl_xfer_seq_chk.sv
module ctrl_xfer_seq_chk #(
  parameter int MPS   = 64,
  parameter int PKT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             setup_valid,
  input logic             in_busy,
  input logic             cmd_send,
  input logic [PKT_W-1:0] cmd_len,
  input logic             cmd_zlp,
  input logic             cmd_stall,
  input logic             done_tx,
  input logic             done_rx,
  input logic             out_open
);
  localparam logic [PKT_W-1:0] MPS_P = PKT_W'(MPS);

  AST_SEND_WAITS_IDLE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n) cmd_send |-> !in_busy); // R3
  AST_ZLP_WAITS_IDLE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n) cmd_zlp |-> !in_busy); // R7
  AST_SEND_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cmd_send |-> cmd_len <= MPS_P); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({cmd_send, cmd_zlp, cmd_stall, done_tx, done_rx})); // R8
  AST_STALL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_stall |=> !out_open && !cmd_send && !cmd_zlp); // R8
  AST_TX_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) done_tx |=> !out_open); // R5
  AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) setup_valid |-> !cmd_send && !cmd_stall); // R9

endmodule

bind ctrl_xfer_seq ctrl_xfer_seq_chk #(.MPS(MPS), .PKT_W(PKT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .setup_valid (setup_valid),
  .in_busy     (in_busy),
  .cmd_send    (cmd_send),
  .cmd_len     (cmd_len),
  .cmd_zlp     (cmd_zlp),
  .cmd_stall   (cmd_stall),
  .done_tx     (done_tx),
  .done_rx     (done_rx),
  .out_open    (out_open)
);

// File: tb/ctrl_xfer_seq_tb.sv
module ctrl_xfer_seq_tb_top;
  localparam int LEN_W = 16;
  localparam int MPS   = 64;
  localparam int MAXX  = 1024;
  localparam int PKT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_valid = 1'b0;
  logic setup_dir_in = 1'b0;
  logic [LEN_W-1:0] setup_req_len = '0;
  logic [LEN_W-1:0] setup_reply_len = '0;
  logic in_busy = 1'b0;
  logic in_done = 1'b0;
  logic out_rcvd = 1'b0;
  logic [PKT_W-1:0] out_len = '0;
  logic cmd_send, cmd_zlp, out_open, cmd_stall, done_tx, done_rx;
  logic [PKT_W-1:0] cmd_len;
  logic [LEN_W-1:0] cmd_offset;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ctrl_xfer_seq #(.LEN_W(LEN_W), .MPS(MPS), .MAX_XFER(MAXX)) dut_i (
    .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_dir_in(setup_dir_in),
    .setup_req_len(setup_req_len), .setup_reply_len(setup_reply_len),
    .in_busy(in_busy), .in_done(in_done), .out_rcvd(out_rcvd), .out_len(out_len),
    .cmd_send(cmd_send), .cmd_len(cmd_len), .cmd_offset(cmd_offset), .cmd_zlp(cmd_zlp),
    .out_open(out_open), .cmd_stall(cmd_stall), .done_tx(done_tx), .done_rx(done_rx)
  );

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int reply_bytes(input int req, input int reply);
    return mn(reply, mn(req, MAXX));
  endfunction

  function automatic bit wants_empty_tail(input int req, input int reply);
    int r = reply_bytes(req, reply);
    int q = mn(req, MAXX);
    return (r > 0) && (r < q) && (r % MPS == 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic next_cycle;
    @(posedge clk);
    #1;
  endtask

  task automatic do_setup(input bit dir_in, input int req, input int reply);
    setup_valid = 1'b1;
    setup_dir_in = dir_in;
    setup_req_len = 16'(req);
    setup_reply_len = 16'(reply);
    in_busy = 1'b0;
    @(negedge clk);
    chk("R9 send held in setup cycle", int'(cmd_send), 0);
    chk("R9 stall held in setup cycle", int'(cmd_stall), 0);
    next_cycle();
    setup_valid = 1'b0;
  endtask

  task automatic run_in(input int req, input int reply);
    int r = reply_bytes(req, reply);
    int npk = (r == 0) ? 1 : ((r + MPS - 1) / MPS) + int'(wants_empty_tail(req, reply));
    do_setup(1'b1, req, reply);
    for (int k = 0; k < npk; k++) begin
      int elen = (k * MPS < r) ? mn(MPS, r - k * MPS) : 0;
      int eoff = (k * MPS < r) ? k * MPS : 0;
      int w = int'($urandom % 3);
      for (int j = 0; j < w; j++) begin
        in_busy = 1'b1;
        @(negedge clk);
        chk("R3 send waits while busy", int'(cmd_send), 0);
        next_cycle();
      end
      in_busy = 1'b0;
      @(negedge clk);
      chk("R2 send issued", int'(cmd_send), 1);
      chk((k == npk - 1 && wants_empty_tail(req, reply)) ? "R4 empty tail length" : "R2 send length",
          int'(cmd_len), elen);
      chk("R2 send offset", int'(cmd_offset), eoff);
      next_cycle();
      in_done = 1'b1;
      @(negedge clk);
      chk("R8 no stall on legal IN done", int'(cmd_stall), 0);
      next_cycle();
      in_done = 1'b0;
    end
    out_rcvd = 1'b1;
    out_len = '0;
    @(negedge clk);
    chk("R5 out opened for status", int'(out_open), 1);
    chk("R5 done_tx pulse", int'(done_tx), 1);
    next_cycle();
    out_rcvd = 1'b0;
    @(negedge clk);
    chk("R5 idle after status", int'(out_open), 0);
    chk("R4 no surplus send", int'(cmd_send), 0);
  endtask

  task automatic run_out(input int req);
    int q = mn(req, MAXX);
    int got = 0;
    int npk = 0;
    do_setup(1'b0, req, 0);
    @(negedge clk);
    chk("R6 out opened", int'(out_open), 1);
    do begin
      int e = mn(MPS, q - got);
      next_cycle();
      out_rcvd = 1'b1;
      out_len = 7'(e);
      @(negedge clk);
      chk("R6 expected OUT length accepted", int'(cmd_stall), 0);
      next_cycle();
      out_rcvd = 1'b0;
      got += e;
      npk++;
    end while (got < q);
    if (req > MAXX) chk("R10 clamped packet count", npk, MAXX / MPS);
    for (int j = 0; j < int'($urandom % 3); j++) begin
      in_busy = 1'b1;
      @(negedge clk);
      chk("R3 status waits while busy", int'(cmd_zlp), 0);
      next_cycle();
    end
    in_busy = 1'b0;
    @(negedge clk);
    chk("R7 empty status issued", int'(cmd_zlp), 1);
    next_cycle();
    in_done = 1'b1;
    @(negedge clk);
    chk("R7 done_rx pulse", int'(done_rx), 1);
    next_cycle();
    in_done = 1'b0;
    @(negedge clk);
    chk("R7 idle after status", int'(out_open), 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) next_cycle();
    @(negedge clk);
    chk("R1 reset send", int'(cmd_send), 0);
    chk("R1 reset out_open", int'(out_open), 0);
    chk("R1 reset stall", int'(cmd_stall), 0);
    chk("R1 reset done", int'(done_tx | done_rx | cmd_zlp), 0);
    next_cycle();
    rst_n = 1'b1;
    next_cycle();

    // R8: events while idle
    in_done = 1'b1;
    @(negedge clk);
    chk("R8 IN done while idle stalls", int'(cmd_stall), 1);
    next_cycle();
    in_done = 1'b0;
    out_rcvd = 1'b1;
    @(negedge clk);
    chk("R8 OUT while idle stalls", int'(cmd_stall), 1);
    next_cycle();
    out_rcvd = 1'b0;

    // R4 corner lengths
    run_in(100, 64);
    run_in(64, 64);
    run_in(255, 128);
    run_in(10, 0);
    run_in(130, 130);
    // R10 clamp both ways
    run_in(3000, 3000);
    run_in(2000, 1024);
    run_out(2000);
    run_out(0);
    run_out(64);
    run_out(128);

    // R8: IN done before the packet was issued
    do_setup(1'b1, 50, 50);
    in_busy = 1'b1;
    in_done = 1'b1;
    @(negedge clk);
    chk("R8 early IN done stalls", int'(cmd_stall), 1);
    next_cycle();
    in_done = 1'b0;
    in_busy = 1'b0;
    @(negedge clk);
    chk("R8 nothing sent after stall", int'(cmd_send), 0);
    chk("R8 out closed after stall", int'(out_open), 0);
    next_cycle();

    // R6: wrong OUT length
    do_setup(1'b0, 100, 0);
    out_rcvd = 1'b1;
    out_len = 7'd64;
    @(negedge clk);
    chk("R6 first chunk ok", int'(cmd_stall), 0);
    next_cycle();
    out_len = 7'd30;
    @(negedge clk);
    chk("R6 short OUT stalls", int'(cmd_stall), 1);
    next_cycle();
    out_rcvd = 1'b0;
    @(negedge clk);
    chk("R6 idle after bad length", int'(out_open), 0);
    next_cycle();

    // R9: abort IN transfer with a new setup while a send is owed
    do_setup(1'b1, 300, 300);
    next_cycle();
    in_done = 1'b1;
    next_cycle();
    in_done = 1'b0;
    run_out(10);

    for (int i = 0; i < 24; i++) begin
      int rq = int'($urandom % 1500);
      int rp = int'($urandom % 1500);
      if ($urandom % 2 == 0) run_in(rq, rp);
      else run_out(rq);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule